// File: doc/BRIEF.md
# Cross-Domain Shadow Update Tracker

This block links a register interface running on a fast bus clock to watchdog counting logic running on a slower, independent kernel clock. Four configuration values (prescaler code, reload value, window threshold and early-warning compare value) are written on the bus side. Each value is carried into a shadow register in the kernel domain by its own toggle handshake. The same mechanism carries a refresh command across as a one-cycle kernel pulse. Each channel shows a busy flag on the bus side from the cycle after an accepted write until the kernel domain has taken the value and its acknowledge has come back. A channel that is busy accepts no new write.

A load of the window or early-compare shadow also makes the block request a counter reload in the kernel domain. The request uses the same pulse output as an explicit refresh, so the counter can be reloaded with a fresh period after either threshold changes. Reads return the kernel-domain shadow of the selected channel. Such a read is only meaningful while that channel's busy flag is low. Key decoding, counter arithmetic and the down-counter itself belong to neighbouring blocks. Both resets are assumed to be asserted asynchronously and released in step with their own clock.

Top module: `shadow_xfer_tracker`

## Requirements
- R1: After reset, reads return 0 for the prescaler channel (wr_sel/rd_sel 0), all ones for reload (1) and window (2), and 0 for early-compare (3). All busy flags and refresh_busy are low.
- R2: A write with wr_en high while the addressed channel is idle sets that channel's bit of busy at the next bus clock edge. The other channels' bits are unaffected.
- R3: A busy flag falls within 40 bus cycles of its write. The kernel shadow, read back through rd_data, then equals the written value.
- R4: A write to a channel whose busy flag is high is ignored. The shadow keeps the value of the transfer already in flight.
- R5: Each landed transfer on the window or early-compare channel produces exactly one k_cnt_load pulse. Transfers on the prescaler and reload channels produce none.
- R6: A refresh_req on an idle refresh path raises refresh_busy at the next bus edge. It then produces exactly one single-cycle k_cnt_load pulse before refresh_busy falls.
- R7: A refresh_req issued while refresh_busy is high is ignored and produces no further k_cnt_load pulse. A refresh issued after refresh_busy has fallen is accepted.
- R8: The bus-side data of a channel stays stable while that channel is busy. A kernel shadow changes only in the cycle after its transfer lands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bus clock |
| brst_n | input | 1 | Bus-domain reset, active low |
| kclk | input | 1 | Kernel clock |
| krst_n | input | 1 | Kernel-domain reset, active low |
| wr_en | input | 1 | Configuration write strobe (bus domain) |
| wr_sel | input | 2 | Channel of the write: 0 prescaler, 1 reload, 2 window, 3 early-compare |
| wr_data | input | DW | Value to write |
| refresh_req | input | 1 | Refresh command strobe (bus domain) |
| rd_sel | input | 2 | Channel whose shadow is returned on rd_data |
| rd_data | output | DW | Kernel shadow of the selected channel |
| busy | output | 4 | Per-channel transfer-in-progress flags (bus domain) |
| refresh_busy | output | 1 | Refresh transfer in progress (bus domain) |
| k_presc | output | DW | Prescaler shadow (kernel domain) |
| k_reload_val | output | DW | Reload shadow (kernel domain) |
| k_window | output | DW | Window shadow (kernel domain) |
| k_early | output | DW | Early-compare shadow (kernel domain) |
| k_cnt_load | output | 1 | One-kernel-cycle counter reload request |

## Verification
The busy and refresh_busy flags are registered from the accepting bus edge, so the bench samples them on the bus falling edge just after the strobe is dropped. The shadow value, and any kernel reload pulse, land two to three kernel edges later. The acknowledge then takes two to three bus edges to return, so the bench polls the busy flag on falling bus edges with a 40-cycle limit rather than expecting one exact cycle. It reads the shadow and the kernel pulse count only after the flag has fallen, when both are certain to have settled. Ignored writes and refreshes are judged by the shadow and the pulse count once the transfer in flight has finished.

// File: rtl/shx_pkg.sv
package shx_pkg;
  localparam int NCH = 4;

  typedef enum logic [1:0] {
    SEL_PRESC  = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_WINDOW = 2'd2,
    SEL_EARLY  = 2'd3
  } chan_sel_e;

  // Channels whose landing requests a counter reload
  function automatic logic chan_autoload(input int idx);
    return (idx == int'(SEL_WINDOW)) || (idx == int'(SEL_EARLY));
  endfunction

  // Channels that come out of reset at all ones
  function automatic logic chan_rst_ones(input int idx);
    return (idx == int'(SEL_RELOAD)) || (idx == int'(SEL_WINDOW));
  endfunction
endpackage

// File: rtl/shx_toggle_hs.sv
module shx_toggle_hs (
  input  logic bclk,
  input  logic brst_n,
  input  logic kclk,
  input  logic krst_n,
  input  logic b_start,
  output logic b_busy,
  output logic k_fire
);
  // bus side: request toggle and returning acknowledge synchronizer
  logic req_q, req_d;
  logic ack_s1_q, ack_s2_q;
  // kernel side: request synchronizer and last-seen toggle
  logic req_s1_q, req_s2_q, seen_q, seen_d;

  assign b_busy = req_q ^ ack_s2_q;

  always_comb begin
    req_d = req_q;
    if (b_start && !b_busy) req_d = ~req_q;
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) begin
      req_q    <= 1'b0;
      ack_s1_q <= 1'b0;
      ack_s2_q <= 1'b0;
    end else begin
      req_q    <= req_d;
      ack_s1_q <= seen_q;
      ack_s2_q <= ack_s1_q;
    end
  end

  assign k_fire = req_s2_q ^ seen_q;

  always_comb begin
    seen_d = seen_q;
    if (k_fire) seen_d = req_s2_q;
  end

  always_ff @(posedge kclk or negedge krst_n) begin
    if (!krst_n) begin
      req_s1_q <= 1'b0;
      req_s2_q <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      req_s1_q <= req_q;
      req_s2_q <= req_s1_q;
      seen_q   <= seen_d;
    end
  end

  // R2 / R6: an accepted start shows as busy on the next bus edge
  p_busy_after_start_r2: assert property (@(posedge bclk) disable iff (!brst_n)
    (b_start && !b_busy) |=> b_busy);

  // R6: each landing is a single kernel-cycle pulse
  p_fire_single_r6: assert property (@(posedge kclk) disable iff (!krst_n)
    k_fire |=> !k_fire);
endmodule

// File: rtl/shx_shadow_chan.sv
module shx_shadow_chan #(
  parameter int              DW  = 12,
  parameter logic [DW-1:0]   RST = '0
) (
  input  logic          bclk,
  input  logic          brst_n,
  input  logic          kclk,
  input  logic          krst_n,
  input  logic          b_wr,
  input  logic [DW-1:0] b_data,
  output logic          b_busy,
  output logic [DW-1:0] k_shadow,
  output logic          k_landed
);
  logic [DW-1:0] hold_q, hold_d;
  logic [DW-1:0] shad_q, shad_d;
  logic          accept;

  assign accept = b_wr & ~b_busy;

  shx_toggle_hs u_hs (
    .bclk    (bclk),
    .brst_n  (brst_n),
    .kclk    (kclk),
    .krst_n  (krst_n),
    .b_start (b_wr),
    .b_busy  (b_busy),
    .k_fire  (k_landed)
  );

  // bus-side holding register, frozen while the transfer is open
  always_comb begin
    hold_d = hold_q;
    if (accept) hold_d = b_data;
  end

  always_ff @(posedge bclk or negedge brst_n) begin
    if (!brst_n) hold_q <= RST;
    else         hold_q <= hold_d;
  end

  // kernel shadow, captured when the toggle lands
  always_comb begin
    shad_d = shad_q;
    if (k_landed) shad_d = hold_q;
  end

  always_ff @(posedge kclk or negedge krst_n) begin
    if (!krst_n) shad_q <= RST;
    else         shad_q <= shad_d;
  end

  assign k_shadow = shad_q;

  // R8: data crossing the boundary does not move while in flight
  p_hold_stable_r8: assert property (@(posedge bclk) disable iff (!brst_n)
    b_busy |=> $stable(hold_q));

  // R8: the shadow only moves after a landing
  p_shadow_quiet_r8: assert property (@(posedge kclk) disable iff (!krst_n)
    !k_landed |=> $stable(shad_q));
endmodule

// File: rtl/shadow_xfer_tracker.sv
module shadow_xfer_tracker #(
  parameter int DW = 12
) (
  input  logic                           bclk,
  input  logic                           brst_n,
  input  logic                           kclk,
  input  logic                           krst_n,
  input  logic                           wr_en,
  input  logic [$clog2(shx_pkg::NCH)-1:0] wr_sel,
  input  logic [DW-1:0]                  wr_data,
  input  logic                           refresh_req,
  input  logic [$clog2(shx_pkg::NCH)-1:0] rd_sel,
  output logic [DW-1:0]                  rd_data,
  output logic [shx_pkg::NCH-1:0]        busy,
  output logic                           refresh_busy,
  output logic [DW-1:0]                  k_presc,
  output logic [DW-1:0]                  k_reload_val,
  output logic [DW-1:0]                  k_window,
  output logic [DW-1:0]                  k_early,
  output logic                           k_cnt_load
);
  import shx_pkg::*;

  localparam int SW = $clog2(NCH);

  logic [DW-1:0]  shad [NCH];
  logic [NCH-1:0] landed;
  logic [NCH-1:0] auto_mask;
  logic           ref_fire;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    localparam logic [DW-1:0] RV = chan_rst_ones(i) ? {DW{1'b1}} : {DW{1'b0}};
    logic sel_hit;
    assign sel_hit      = wr_en && (wr_sel == SW'(i));
    assign auto_mask[i] = chan_autoload(i);

    shx_shadow_chan #(.DW(DW), .RST(RV)) u_chan (
      .bclk     (bclk),
      .brst_n   (brst_n),
      .kclk     (kclk),
      .krst_n   (krst_n),
      .b_wr     (sel_hit),
      .b_data   (wr_data),
      .b_busy   (busy[i]),
      .k_shadow (shad[i]),
      .k_landed (landed[i])
    );
  end

  shx_toggle_hs u_refresh (
    .bclk    (bclk),
    .brst_n  (brst_n),
    .kclk    (kclk),
    .krst_n  (krst_n),
    .b_start (refresh_req),
    .b_busy  (refresh_busy),
    .k_fire  (ref_fire)
  );

  assign k_cnt_load   = ref_fire | (|(landed & auto_mask));
  assign rd_data      = shad[rd_sel];
  assign k_presc      = shad[SEL_PRESC];
  assign k_reload_val = shad[SEL_RELOAD];
  assign k_window     = shad[SEL_WINDOW];
  assign k_early      = shad[SEL_EARLY];
endmodule

// File: tb/shadow_xfer_tracker_bench.sv
module shadow_xfer_tracker_bench;
  localparam int DW = 12;

  logic          bclk = 1'b0, kclk = 1'b0;
  logic          brst_n = 1'b0, krst_n = 1'b0;
  logic          wr_en = 1'b0, refresh_req = 1'b0;
  logic [1:0]    wr_sel = '0, rd_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data, k_presc, k_reload_val, k_window, k_early;
  logic [3:0]    busy;
  logic          refresh_busy, k_cnt_load;

  int checks = 0, errors = 0, loads = 0, cyc = 0;
  bit done = 1'b0;

  always #2 bclk = ~bclk;  // 250 MHz bus clock
  always #7 kclk = ~kclk;  // slower kernel clock

  shadow_xfer_tracker #(.DW(DW)) u_shadow_xfer_tracker (
    .bclk(bclk), .brst_n(brst_n), .kclk(kclk), .krst_n(krst_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .refresh_req(refresh_req), .rd_sel(rd_sel), .rd_data(rd_data),
    .busy(busy), .refresh_busy(refresh_busy),
    .k_presc(k_presc), .k_reload_val(k_reload_val), .k_window(k_window),
    .k_early(k_early), .k_cnt_load(k_cnt_load)
  );

  always @(posedge kclk) if (krst_n && k_cnt_load) loads <= loads + 1;

  // vector: {sel[1:0], data[11:0], expects reload pulse}
  localparam logic [14:0] VEC [6] = '{
    {2'd1, 12'h123, 1'b0},
    {2'd0, 12'h005, 1'b0},
    {2'd2, 12'h400, 1'b1},
    {2'd3, 12'h0A5, 1'b1},
    {2'd1, 12'h002, 1'b0},
    {2'd2, 12'hFFF, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [DW-1:0] d);
    @(negedge bclk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge bclk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(input logic [1:0] sel);
    for (int n = 0; n < 40 && busy[sel]; n++) @(negedge bclk);
    chk("R3 busy falls within 40 cycles", 32'(busy[sel]), 0);
  endtask

  task automatic read_ch(input logic [1:0] sel, input logic [DW-1:0] exp, input string tag);
    rd_sel = sel;
    #1;
    chk(tag, 32'(rd_data), 32'(exp));
  endtask

  task automatic do_refresh();
    @(negedge bclk);
    refresh_req = 1'b1;
    @(negedge bclk);
    refresh_req = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge bclk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=<100000", cyc);
      finish_run();
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge bclk);
    brst_n = 1'b1; krst_n = 1'b1;
    repeat (2) @(negedge bclk);

    // R1: reset state
    chk("R1 busy after reset", 32'(busy), 0);
    chk("R1 refresh_busy after reset", 32'(refresh_busy), 0);
    read_ch(2'd0, 12'h000, "R1 prescaler reset");
    read_ch(2'd1, 12'hFFF, "R1 reload reset");
    read_ch(2'd2, 12'hFFF, "R1 window reset");
    read_ch(2'd3, 12'h000, "R1 early reset");

    // table walk: R2, R3, R5
    for (int v = 0; v < 6; v++) begin
      logic [1:0]    s;
      logic [DW-1:0] d;
      logic          al;
      {s, d, al} = VEC[v];
      base = loads;
      do_write(s, d);
      chk("R2 busy set on written channel", 32'(busy[s]), 1);
      chk("R2 other channels idle", 32'(busy & ~(4'b1 << s)), 0);
      wait_idle(s);
      repeat (2) @(negedge bclk);
      read_ch(s, d, "R3 shadow holds written value");
      chk("R5 reload pulses per landing", 32'(loads - base), al ? 1 : 0);
    end
    chk("R3 kernel prescaler port", 32'(k_presc), 32'h005);
    chk("R3 kernel early port", 32'(k_early), 32'h0A5);

    // R4 / R8: second write while busy is dropped
    do_write(2'd1, 12'h111);
    do_write(2'd1, 12'h222);
    wait_idle(2'd1);
    repeat (4) @(negedge bclk);
    read_ch(2'd1, 12'h111, "R4 write during busy ignored");
    chk("R8 reload kernel port kept in-flight value", 32'(k_reload_val), 32'h111);
    read_ch(2'd2, 12'hFFF, "R8 untouched window shadow");

    // R6: single refresh
    base = loads;
    do_refresh();
    chk("R6 refresh_busy raised", 32'(refresh_busy), 1);
    for (int n = 0; n < 40 && refresh_busy; n++) @(negedge bclk);
    chk("R6 refresh_busy falls", 32'(refresh_busy), 0);
    chk("R6 one reload pulse", 32'(loads - base), 1);

    // R7: refresh while in flight dropped, later one accepted
    base = loads;
    do_refresh();
    do_refresh();
    for (int n = 0; n < 40 && refresh_busy; n++) @(negedge bclk);
    repeat (20) @(negedge bclk);
    chk("R7 in-flight refresh ignored", 32'(loads - base), 1);
    do_refresh();
    for (int n = 0; n < 40 && refresh_busy; n++) @(negedge bclk);
    chk("R7 later refresh accepted", 32'(loads - base), 2);

    finish_run();
  end
endmodule